// File: doc/BRIEF.md
# Audio Playback Sequencer with Status Flags

This block decides when buffered isochronous audio is played out to the converter path and when the path is forced to silence. It watches strobes from the packet receiver: a whole 1 ms packet has been stored, the host has sent its final packet, and a start-of-frame has arrived. It also watches the bus-suspend level and the selected stream format. Playback is armed by the first stored packet and starts on the next start-of-frame. From then on, each sample-rate tick pops one sample from the buffer and drives it to the left and right outputs. In mono format one sample word is copied to both channels.

When the host sends its final packet, playback goes on until the buffer runs dry and then returns to idle. A bus suspend, or a format select with no bandwidth, drops the block to idle at once. Three status outputs report the state. The playback flag is active low and low while audio plays. The suspend flag is active low and follows the bus. The silence flag goes high after a run of all-zero sample periods; sample periods in idle count as zero. It starts high after reset.

Top module: `audio_play_seq`

## Requirements
- R1: After reset, play_n_o and susp_n_o are 1, mute_o is 1, zero_o is 1, rd_en_o is 0 and both sample outputs are 0. After mute_o has been 1 for two consecutive cycles, both sample outputs are 0.
- R2: Playback starts (play_n_o falls) only on a sof_i pulse that comes in a later cycle than a pkt_rcvd_i pulse. A sof_i with no stored packet, or in the same cycle as that packet, does not start playback.
- R3: While playing, rd_en_o is 1 in every cycle where smp_tick_i is 1 and buf_empty_i is 0. In stereo format (alt_sel_i = 1), out_left_o and out_right_o show buf_left_i and buf_right_i one clock after the tick.
- R4: In mono format (alt_sel_i = 2), buf_left_i drives both outputs and buf_right_i is ignored.
- R5: A tick while playing with buf_empty_i = 1 keeps rd_en_o at 0, outputs a zero sample and keeps playing.
- R6: After last_pkt_i, playback continues tick by tick until a tick finds the buffer empty. Then play_n_o and mute_o return to 1. A last_pkt_i that arrives while armed is honoured the same way.
- R7: bus_suspend_i = 1 drives susp_n_o low and forces idle (play_n_o = 1) one clock later. Packets are ignored while it is set.
- R8: alt_sel_i = 0 (or the unused code 3) forces idle one clock later. Packets are ignored while it is set.
- R9: zero_o is 1 once ZERO_RUN consecutive ticks (default 1024) have carried a zero sample on both channels; idle ticks count as zero. A nonzero sample on either channel clears zero_o at the same edge that outputs the sample.
- R10: play_n_o is 0 exactly while playing or draining, and mute_o equals play_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_rcvd_i | input | 1 | Pulse: a full 1 ms packet has been stored |
| last_pkt_i | input | 1 | Pulse: host has sent its final packet |
| sof_i | input | 1 | Start-of-frame strobe |
| bus_suspend_i | input | 1 | Bus suspend level |
| alt_sel_i | input | 2 | Format: 0 none, 1 stereo, 2 mono, 3 none |
| smp_tick_i | input | 1 | One pulse per sample period |
| buf_empty_i | input | 1 | Sample buffer has no data |
| buf_left_i | input | DATA_W | Head-of-buffer left (or mono) sample |
| buf_right_i | input | DATA_W | Head-of-buffer right sample |
| rd_en_o | output | 1 | Pop one sample from the buffer |
| mute_o | output | 1 | Force converter path to zero |
| out_left_o | output | DATA_W | Left sample to converter |
| out_right_o | output | DATA_W | Right sample to converter |
| play_n_o | output | 1 | Playback flag, low while playing |
| susp_n_o | output | 1 | Suspend flag, low while suspended |
| zero_o | output | 1 | Silence flag |

## Verification
The bench aims at arming order: a start-of-frame with no packet, or in the same cycle as the packet, must not start playback. A design that starts too early would play before a full packet is stored. The silence counter is driven through exactly ZERO_RUN zero ticks and then one nonzero sample; an off-by-one counter raises the flag one tick early or late. Underrun and drain are told apart: an empty buffer while playing must output silence and keep going, while the same condition after the final packet must end playback. Mono copying, and abort by suspend or zero-bandwidth with packets arriving during the abort, are checked against a bench model of outputs and flags.

// File: rtl/aps_pkg.sv
// Shared types for the audio playback sequencer.
package aps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PLAY  = 2'd2,
        ST_DRAIN = 2'd3
    } aps_state_e;

    localparam logic [1:0] ALT_NONE   = 2'd0;
    localparam logic [1:0] ALT_STEREO = 2'd1;
    localparam logic [1:0] ALT_MONO   = 2'd2;

    // True when the format select carries audio.
    function automatic logic alt_streams(input logic [1:0] alt);
        return (alt == ALT_STEREO) || (alt == ALT_MONO);
    endfunction
endpackage

// File: rtl/aps_ctrl.sv
// Sequencing state machine: arms on a stored packet, starts on the next
// start-of-frame, drains after the final packet, aborts on suspend or a
// zero-bandwidth format. Assumes all strobes are single-cycle and synchronous.
module aps_ctrl
    import aps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pkt_rcvd_i,
    input  logic       last_pkt_i,
    input  logic       sof_i,
    input  logic       bus_suspend_i,
    input  logic [1:0] alt_sel_i,
    input  logic       smp_tick_i,
    input  logic       buf_empty_i,
    output logic       playing_o,
    output logic       rd_en_o
);
    aps_state_e st_q, st_d;
    logic       last_seen_q, last_seen_d;
    logic       abort;

    assign abort = bus_suspend_i || !alt_streams(alt_sel_i);

    // Next-state selection; abort has priority over every other event.
    always_comb begin
        st_d        = st_q;
        last_seen_d = last_seen_q;
        if (abort) begin
            st_d        = ST_IDLE;
            last_seen_d = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    last_seen_d = 1'b0;
                    if (pkt_rcvd_i) st_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (last_pkt_i) last_seen_d = 1'b1;
                    if (sof_i) begin
                        st_d        = (last_seen_q || last_pkt_i) ? ST_DRAIN : ST_PLAY;
                        last_seen_d = 1'b0;
                    end
                end
                ST_PLAY: begin
                    if (last_pkt_i) st_d = ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (smp_tick_i && buf_empty_i) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            last_seen_q <= 1'b0;
        end else begin
            st_q        <= st_d;
            last_seen_q <= last_seen_d;
        end
    end

    assign playing_o = (st_q == ST_PLAY) || (st_q == ST_DRAIN);
    assign rd_en_o   = playing_o && smp_tick_i && !buf_empty_i;
endmodule

// File: rtl/aps_chan_map.sv
// Channel mapper: picks the sample for this tick (mono copy, underrun
// silence) and holds the converter outputs; clears them while not playing.
module aps_chan_map #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              playing_i,
    input  logic              mono_i,
    input  logic              smp_tick_i,
    input  logic              buf_empty_i,
    input  logic [DATA_W-1:0] buf_left_i,
    input  logic [DATA_W-1:0] buf_right_i,
    output logic              smp_vld_o,
    output logic [DATA_W-1:0] nxt_left_o,
    output logic [DATA_W-1:0] nxt_right_o,
    output logic [DATA_W-1:0] out_left_o,
    output logic [DATA_W-1:0] out_right_o
);
    // Sample selection for the current tick.
    always_comb begin
        if (buf_empty_i) begin
            nxt_left_o  = '0;
            nxt_right_o = '0;
        end else begin
            nxt_left_o  = buf_left_i;
            nxt_right_o = mono_i ? buf_left_i : buf_right_i;
        end
    end

    assign smp_vld_o = playing_i && smp_tick_i;

    // Output hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !playing_i) begin
            out_left_o  <= '0;
            out_right_o <= '0;
        end else if (smp_tick_i) begin
            out_left_o  <= nxt_left_o;
            out_right_o <= nxt_right_o;
        end
    end
endmodule

// File: rtl/aps_zero_det.sv
// Silence detector: counts consecutive zero sample periods up to ZERO_RUN.
// Idle ticks count as zero; starts saturated so the flag is high after reset.
module aps_zero_det #(
    parameter int DATA_W   = 16,
    parameter int ZERO_RUN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick_i,
    input  logic              smp_vld_i,
    input  logic [DATA_W-1:0] nxt_left_i,
    input  logic [DATA_W-1:0] nxt_right_i,
    output logic              zero_o
);
    localparam int CNT_W = $clog2(ZERO_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(ZERO_RUN);

    logic [CNT_W-1:0] run_q;
    logic             loud;

    assign loud = smp_vld_i && ((nxt_left_i != '0) || (nxt_right_i != '0));

    // Run counter, cleared by any audible sample, saturating at RUN_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= RUN_MAX;
        end else if (smp_tick_i) begin
            if (loud)                run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assign zero_o = (run_q == RUN_MAX);
endmodule

// File: rtl/audio_play_seq.sv
// Top of the audio playback sequencer. Ties the state machine, channel
// mapper and silence detector together and registers the suspend flag.
// Assumes buf_* present the head of a show-ahead buffer popped by rd_en_o.
module audio_play_seq
    import aps_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ZERO_RUN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_rcvd_i,
    input  logic              last_pkt_i,
    input  logic              sof_i,
    input  logic              bus_suspend_i,
    input  logic [1:0]        alt_sel_i,
    input  logic              smp_tick_i,
    input  logic              buf_empty_i,
    input  logic [DATA_W-1:0] buf_left_i,
    input  logic [DATA_W-1:0] buf_right_i,
    output logic              rd_en_o,
    output logic              mute_o,
    output logic [DATA_W-1:0] out_left_o,
    output logic [DATA_W-1:0] out_right_o,
    output logic              play_n_o,
    output logic              susp_n_o,
    output logic              zero_o
);
    logic              playing;
    logic              smp_vld;
    logic [DATA_W-1:0] nxt_l, nxt_r;
    logic              susp_n_q;

    aps_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_rcvd_i    (pkt_rcvd_i),
        .last_pkt_i    (last_pkt_i),
        .sof_i         (sof_i),
        .bus_suspend_i (bus_suspend_i),
        .alt_sel_i     (alt_sel_i),
        .smp_tick_i    (smp_tick_i),
        .buf_empty_i   (buf_empty_i),
        .playing_o     (playing),
        .rd_en_o       (rd_en_o)
    );

    aps_chan_map #(.DATA_W(DATA_W)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .playing_i   (playing),
        .mono_i      (alt_sel_i == ALT_MONO),
        .smp_tick_i  (smp_tick_i),
        .buf_empty_i (buf_empty_i),
        .buf_left_i  (buf_left_i),
        .buf_right_i (buf_right_i),
        .smp_vld_o   (smp_vld),
        .nxt_left_o  (nxt_l),
        .nxt_right_o (nxt_r),
        .out_left_o  (out_left_o),
        .out_right_o (out_right_o)
    );

    aps_zero_det #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_zero (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_tick_i  (smp_tick_i),
        .smp_vld_i   (smp_vld),
        .nxt_left_i  (nxt_l),
        .nxt_right_i (nxt_r),
        .zero_o      (zero_o)
    );

    // Suspend flag register (active low).
    always_ff @(posedge clk) begin
        if (!rst_n) susp_n_q <= 1'b1;
        else        susp_n_q <= !bus_suspend_i;
    end

    assign susp_n_o = susp_n_q;
    assign play_n_o = !playing;
    assign mute_o   = !playing;
endmodule

// File: rtl/aps_chk.sv
// Property checker for audio_play_seq, attached by bind.
module aps_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sof_i,
    input logic              bus_suspend_i,
    input logic [1:0]        alt_sel_i,
    input logic              smp_tick_i,
    input logic [DATA_W-1:0] buf_left_i,
    input logic              rd_en_o,
    input logic              mute_o,
    input logic [DATA_W-1:0] out_left_o,
    input logic [DATA_W-1:0] out_right_o,
    input logic              play_n_o,
    input logic              susp_n_o,
    input logic              zero_o
);
    AST_START_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(play_n_o) |-> $past(sof_i)); // R2
    AST_READ_WHILE_PLAYING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> !play_n_o); // R3
    AST_MONO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_n_o && smp_tick_i && alt_sel_i == 2'd2) |=> (out_left_o == out_right_o)); // R4
    AST_SUSPEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_suspend_i |=> (play_n_o && !susp_n_o)); // R7
    AST_NO_BW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_sel_i == 2'd0) |=> play_n_o); // R8
    AST_LOUD_CLEARS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && buf_left_i != '0) |=> !zero_o); // R9
    AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_o && $past(mute_o)) |-> (out_left_o == '0 && out_right_o == '0)); // R1
endmodule

bind audio_play_seq aps_chk #(.DATA_W(DATA_W)) u_aps_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sof_i         (sof_i),
    .bus_suspend_i (bus_suspend_i),
    .alt_sel_i     (alt_sel_i),
    .smp_tick_i    (smp_tick_i),
    .buf_left_i    (buf_left_i),
    .rd_en_o       (rd_en_o),
    .mute_o        (mute_o),
    .out_left_o    (out_left_o),
    .out_right_o   (out_right_o),
    .play_n_o      (play_n_o),
    .susp_n_o      (susp_n_o),
    .zero_o        (zero_o)
);

// File: tb/audio_play_seq_tb.sv
module audio_play_seq_tb;
    localparam int DW  = 16;
    localparam int RUN = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt = 0, last = 0, sof = 0, susp = 0, tick = 0, empty = 1;
    logic [1:0]    alt = 2'd0;
    logic [DW-1:0] bl = '0, br = '0;
    logic          rd_en, mute, play_n, susp_n, zero;
    logic [DW-1:0] ol, orr;

    int checks = 0, errors = 0;
    int zc = RUN;          // model of the silence run
    bit exp_play = 0;      // model of playback state

    always #10 clk = ~clk;

    audio_play_seq #(.DATA_W(DW), .ZERO_RUN(RUN)) u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_rcvd_i(pkt), .last_pkt_i(last),
        .sof_i(sof), .bus_suspend_i(susp), .alt_sel_i(alt),
        .smp_tick_i(tick), .buf_empty_i(empty), .buf_left_i(bl),
        .buf_right_i(br), .rd_en_o(rd_en), .mute_o(mute),
        .out_left_o(ol), .out_right_o(orr), .play_n_o(play_n),
        .susp_n_o(susp_n), .zero_o(zero)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_right(input logic [DW-1:0] l, input logic [DW-1:0] r);
        return (alt == 2'd2) ? l : r;
    endfunction

    // One sample period: drive, check read enable, clock, check outputs/flag.
    task automatic do_tick(input logic [DW-1:0] l, input logic [DW-1:0] r, input bit emp, input string req);
        logic [DW-1:0] el, er;
        bl = l; br = r; empty = emp; tick = 1;
        #2;
        chk({req, " rd_en"}, rd_en, exp_play && !emp);
        el = (exp_play && !emp) ? l : '0;
        er = (exp_play && !emp) ? exp_right(l, r) : '0;
        if (exp_play && (el != 0 || er != 0)) zc = 0;
        else if (zc < RUN) zc++;
        @(negedge clk);
        tick = 0;
        if (exp_play) begin
            chk({req, " left"}, ol, el);
            chk({req, " right"}, orr, er);
        end
        chk("R9 zero", zero, zc >= RUN);
    endtask

    task automatic pulse(ref logic s);
        s = 1; @(negedge clk); s = 0;
    endtask

    task automatic start_play();
        pulse(pkt); pulse(sof); exp_play = 1;
        chk("R2 start", play_n, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 play_n", play_n, 1); chk("R1 susp_n", susp_n, 1);
        chk("R1 mute", mute, 1);     chk("R1 zero", zero, 1);
        chk("R1 rd_en", rd_en, 0);   chk("R1 out", {ol, orr}, 0);

        // R2 sof without packet, packet and sof together, then later sof
        alt = 2'd1;
        pulse(sof); chk("R2 sof alone", play_n, 1);
        pkt = 1; sof = 1; @(negedge clk); pkt = 0; sof = 0;
        chk("R2 same cycle", play_n, 1);
        pulse(sof); exp_play = 1; chk("R2 later sof", play_n, 0);
        chk("R10 mute", mute, 0);

        // R3 stereo random samples with some zeros
        for (int i = 0; i < 40; i++)
            do_tick(($urandom % 4 == 0) ? '0 : DW'($urandom), DW'($urandom), 0, "R3");
        // R5 underrun
        do_tick(16'h1234, 16'h5678, 1, "R5");
        chk("R5 still playing", play_n, 0);
        // R4 mono
        alt = 2'd2;
        for (int i = 0; i < 20; i++) do_tick(DW'($urandom), DW'($urandom), 0, "R4");
        do_tick(16'h00A5, 16'hFFFF, 0, "R4 directed");
        // R9 run of zeros, boundary, then a nonzero right-only stereo sample
        alt = 2'd1;
        for (int i = 0; i < RUN; i++) do_tick('0, '0, 0, "R9 run");
        chk("R9 flag at run", zero, 1);
        do_tick('0, 16'h0001, 0, "R9 clear");
        chk("R9 cleared", zero, 0);

        // R6 drain after final packet
        pulse(last);
        chk("R6 draining", play_n, 0);
        for (int i = 0; i < 5; i++) do_tick(DW'($urandom) | 16'h1, DW'($urandom), 0, "R6");
        chk("R6 still playing", play_n, 0);
        do_tick('0, '0, 1, "R6 empty");
        exp_play = 0;
        chk("R6 idle", play_n, 1); chk("R10 mute idle", mute, 1);

        // R7 suspend aborts, packets ignored
        start_play();
        do_tick(16'h0F0F, 16'hF0F0, 0, "R7 pre");
        susp = 1; @(negedge clk); exp_play = 0;
        chk("R7 susp_n", susp_n, 0); chk("R7 idle", play_n, 1);
        @(negedge clk);
        chk("R1 out cleared", {ol, orr}, 0);
        pulse(pkt); susp = 0; @(negedge clk); pulse(sof);
        chk("R7 pkt ignored", play_n, 1);
        chk("R7 susp_n back", susp_n, 1);

        // R8 zero bandwidth aborts, packets ignored
        start_play();
        alt = 2'd0; @(negedge clk); exp_play = 0;
        chk("R8 idle", play_n, 1);
        pulse(pkt); alt = 2'd3; @(negedge clk); alt = 2'd1; pulse(sof);
        chk("R8 pkt ignored", play_n, 1);

        // R6 final packet while armed
        pulse(pkt); pulse(last); pulse(sof); exp_play = 1;
        chk("R6 armed last", play_n, 0);
        do_tick(16'h0042, 16'h0043, 0, "R6 one");
        do_tick('0, '0, 1, "R6 end");
        exp_play = 0;
        chk("R6 armed idle", play_n, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule